// File: doc/BRIEF.md
# Eight-Channel Endpoint DMA Engine

This block moves data between USB endpoint FIFOs and system memory on behalf of eight independent channels. Software sets up each channel through a small register window: a start address, a byte count and a 16-bit control word that carries the endpoint number, the direction, the mode, the burst type and an interrupt enable. Writing the control word with its enable bit set starts the channel. From then on the channel competes for a single bus-master port, and it may compete only while its endpoint FIFO raises a request.

Each time a channel is granted the port, it issues one burst of the length its control word selects. The address register advances by the number of bytes moved, so software can subtract the start address from the current address to find the transfer size. The count register counts down to zero. When a channel finishes, or the bus reports an error, its enable bit drops. If its interrupt enable is set, the channel also sets its bit in a shared interrupt status byte, and that byte clears when it is read.

Top module: `ep_dma_engine`

## Requirements
- R1: After reset, every control, address and count register reads zero, the interrupt status byte reads zero, and both `irq` and `bm_valid` are low.
- R2: Channel n's registers sit at byte address 0x200 + 16·n. The control word is at offset 0x4 and is stored in bits 10:0, with bit 8 always written as 0. The address is at offset 0x8 and is 32 bits wide. The count is at offset 0xC and stores the low 17 bits. Each register reads back what was stored.
- R3: Writing the control word with bit 0 set starts the channel, but bus beats are issued only while `fifo_req[ep]` is high. Bit 1 = 1 selects transmit: the beat reads memory (`bm_wr`=0) and `bm_rdata` goes to `fifo_wdata`. Bit 1 = 0 selects receive: the beat writes memory (`bm_wr`=1) from `fifo_rdata`. Beats use the channel's address register, and `bm_valid` holds with a stable address while `bm_ready` is low.
- R4: Each accepted beat moves min(4, remaining count) bytes, shown on `bm_nbytes`. The address register advances by that amount and the count register falls by it, so the final address equals the start address plus the programmed count.
- R5: Control bits 10:9 select the number of beats per grant: 0 gives 1, 1 gives 4, 2 gives 8 and 3 gives 16. The value appears on `bm_burst`. After each burst the channel releases the port, and `bm_valid` drops for at least one cycle.
- R6: With control bit 2 at 0, the channel stops after 64 bytes (one packet) or when the count reaches zero, whichever comes first. A packet may span several bursts. With bit 2 at 1, the channel runs until the count reaches zero. In both cases the enable bit clears when the channel finishes.
- R7: The byte at 0x200 holds one bit per channel. Bit n is set when channel n finishes or hits a bus error while control bit 3 is set; with bit 3 clear, the bit is not set. A read returns the byte and clears it. `irq` is the OR of the byte.
- R8: A beat answered with `bm_err` sets control bit 8, clears the enable bit and sets the channel's interrupt bit. It leaves the address and count unchanged and does not pulse `fifo_ack`.
- R9: Writing a control word with bit 0 clear stops the channel at once. No further beats are issued, and no interrupt bit is set.
- R10: When several channels are eligible, grants rotate round-robin, starting with the channel after the one granted last.
- R11: Control bits 7:4 select the endpoint. That endpoint's `fifo_req` line gates the channel, and `fifo_ep` shows the endpoint during the channel's beats. Only that endpoint's `fifo_ack` bit pulses on each completed beat.
- R12: Starting a channel with a count of zero finishes it without any bus beat, clears its enable bit and sets its interrupt bit if bit 3 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears the interrupt byte when it addresses it) |
| reg_addr | input | 10 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| irq | output | 1 | OR of the pending interrupt bits |
| bm_valid | output | 1 | Bus beat request |
| bm_ready | input | 1 | Bus beat accepted |
| bm_wr | output | 1 | 1 = memory write, 0 = memory read |
| bm_addr | output | 32 | Beat byte address |
| bm_burst | output | 2 | Burst type of the current grant |
| bm_nbytes | output | 3 | Bytes valid in this beat (1 to 4) |
| bm_wdata | output | 32 | Memory write data |
| bm_rdata | input | 32 | Memory read data |
| bm_err | input | 1 | Bus error for the accepted beat |
| fifo_req | input | 16 | Per-endpoint FIFO request |
| fifo_ack | output | 16 | Per-endpoint FIFO beat acknowledge |
| fifo_ep | output | 4 | Endpoint being served |
| fifo_wdata | output | 32 | Data toward the FIFO (transmit) |
| fifo_rdata | input | 32 | Data from the FIFO (receive) |

## Verification
A channel whose count or address stepped wrongly would show at its next beat: `bm_addr` would break from its running sequence, or the final address would differ from start plus count as soon as the enable bit reads back clear. An arbiter pointer or burst counter that was wrong would appear within the first handful of beats, as an endpoint order on `fifo_ep` that breaks the rotation, or as a run of back-to-back beats longer or shorter than the burst type allows. A stuck enable bit or a lost completion would show as an interrupt byte missing its bit, or as a polled control word that never clears.

// File: rtl/ep_dma_pkg.sv
package ep_dma_pkg;

    localparam int EP_W = 4;
    localparam int NEP  = 1 << EP_W;

    // Control word layout; software decodes these positions.
    typedef struct packed {
        logic [4:0]      rsvd;
        logic [1:0]      burst;
        logic            buserr;
        logic [EP_W-1:0] ep;
        logic            ie;
        logic            mode1;
        logic            tx;
        logic            en;
    } ctrl_t;

    function automatic logic [4:0] burst_len(input logic [1:0] kind);
        case (kind)
            2'd1:    return 5'd4;
            2'd2:    return 5'd8;
            2'd3:    return 5'd16;
            default: return 5'd1;
        endcase
    endfunction

endpackage

// File: rtl/ep_dma_rr_arb.sv
module ep_dma_rr_arb #(
    parameter int N = 8,
    localparam int CW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    input  logic [CW-1:0] last,
    output logic [CW-1:0] gnt,
    output logic          any
);

    // Search starts just after the last winner; the smallest offset wins.
    always_comb begin
        gnt = last;
        any = 1'b0;
        for (int i = N; i >= 1; i--) begin
            int k;
            k = (int'(last) + i) % N;
            if (req[k]) begin
                gnt = CW'(k);
                any = 1'b1;
            end
        end
    end

endmodule

// File: rtl/ep_dma_chan.sv
module ep_dma_chan
    import ep_dma_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int CNT_W     = 17,
    parameter int PKT_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctrl,
    input  logic              wr_addr,
    input  logic              wr_cnt,
    input  logic [31:0]       wdata,
    input  logic              beat,
    input  logic              beat_err,
    input  logic [2:0]        beat_bytes,
    output ctrl_t             ctrl,
    output logic [ADDR_W-1:0] addr,
    output logic [CNT_W-1:0]  cnt,
    output logic              fin
);

    localparam int PKT_W = $clog2(PKT_BYTES) + 1;
    localparam logic [PKT_W-1:0] PKT_LIM = PKT_W'(PKT_BYTES);

    logic [PKT_W-1:0] pkt_moved;
    logic [PKT_W-1:0] pkt_nx;
    logic [CNT_W-1:0] cnt_nx;
    logic             moved_done;
    ctrl_t            ctrl_wr;

    always_comb begin
        cnt_nx     = cnt - CNT_W'(beat_bytes);
        pkt_nx     = pkt_moved + PKT_W'(beat_bytes);
        moved_done = (cnt_nx == '0) || (!ctrl.mode1 && pkt_nx >= PKT_LIM);
        fin        = ctrl.en && !wr_ctrl &&
                     (beat ? (beat_err || moved_done) : (cnt == '0));
        ctrl_wr        = ctrl_t'(wdata[15:0]);
        ctrl_wr.buserr = 1'b0;
        ctrl_wr.rsvd   = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= '0;
            addr      <= '0;
            cnt       <= '0;
            pkt_moved <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl      <= ctrl_wr;
                pkt_moved <= '0;
            end else begin
                if (fin) begin
                    ctrl.en <= 1'b0;
                    if (beat && beat_err) ctrl.buserr <= 1'b1;
                end
                if (beat && !beat_err) pkt_moved <= pkt_nx;
            end
            if (wr_addr)
                addr <= wdata[ADDR_W-1:0];
            else if (beat && !beat_err)
                addr <= addr + {{(ADDR_W-3){1'b0}}, beat_bytes};
            if (wr_cnt)
                cnt <= wdata[CNT_W-1:0];
            else if (beat && !beat_err)
                cnt <= cnt_nx;
        end
    end

    AST_BEAT_ENABLED: assert property (@(posedge clk) disable iff (rst)
        beat |-> ctrl.en);                                             // R3
    AST_FIN_CLEARS_EN: assert property (@(posedge clk) disable iff (rst)
        fin |=> !ctrl.en);                                             // R6
    AST_ERR_NO_MOVE: assert property (@(posedge clk) disable iff (rst)
        (beat && beat_err && !wr_addr) |=> $stable(addr));             // R8

endmodule

// File: rtl/ep_dma_seq.sv
module ep_dma_seq
    import ep_dma_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 17,
    localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctrl [NCH],
    input  logic [ADDR_W-1:0] addr [NCH],
    input  logic [CNT_W-1:0]  cnt  [NCH],
    input  logic [NCH-1:0]    fin,
    input  logic [NEP-1:0]    fifo_req,
    output logic              bm_valid,
    input  logic              bm_ready,
    output logic              bm_wr,
    output logic [ADDR_W-1:0] bm_addr,
    output logic [1:0]        bm_burst,
    output logic [2:0]        bm_nbytes,
    input  logic              bm_err,
    output logic [NCH-1:0]    beat_vec,
    output logic              beat_err,
    output logic [NEP-1:0]    fifo_ack,
    output logic [EP_W-1:0]   fifo_ep
);

    logic [NCH-1:0]  elig;
    logic [CH_W-1:0] gnt, last, cur;
    logic            any, busy, act, beat;
    logic [4:0]      beats_left;
    logic [CNT_W-1:0] cur_cnt;

    always_comb begin
        for (int i = 0; i < NCH; i++)
            elig[i] = ctrl[i].en && (cnt[i] != '0) && fifo_req[ctrl[i].ep];
    end

    ep_dma_rr_arb #(.N(NCH)) u_arb (
        .req (elig),
        .last(last),
        .gnt (gnt),
        .any (any)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy       <= 1'b0;
            cur        <= '0;
            last       <= CH_W'(NCH - 1);
            beats_left <= '0;
        end else if (!busy) begin
            if (any) begin
                busy       <= 1'b1;
                cur        <= gnt;
                last       <= gnt;
                beats_left <= burst_len(ctrl[gnt].burst);
            end
        end else if (!ctrl[cur].en) begin
            busy <= 1'b0;
        end else if (bm_ready) begin
            if (fin[cur] || beats_left == 5'd1) busy <= 1'b0;
            beats_left <= beats_left - 5'd1;
        end
    end

    always_comb begin
        cur_cnt   = cnt[cur];
        act       = busy && ctrl[cur].en;
        beat      = act && bm_ready;
        bm_valid  = act;
        bm_addr   = addr[cur];
        bm_wr     = !ctrl[cur].tx;
        bm_burst  = ctrl[cur].burst;
        bm_nbytes = (cur_cnt >= CNT_W'(4)) ? 3'd4 : cur_cnt[2:0];
        beat_vec  = beat ? (NCH'(1) << cur) : '0;
        beat_err  = bm_err;
        fifo_ack  = (beat && !bm_err) ? (NEP'(1) << ctrl[cur].ep) : '0;
        fifo_ep   = act ? ctrl[cur].ep : '0;
    end

    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (bm_valid && !bm_ready) |=>
            ((bm_valid && $stable(bm_addr)) || !ctrl[cur].en));       // R3
    AST_BEAT_HAS_DATA: assert property (@(posedge clk) disable iff (rst)
        beat |-> (cur_cnt != '0));                                     // R4
    AST_BURST_BOUND: assert property (@(posedge clk) disable iff (rst)
        busy |-> (beats_left != 5'd0 && beats_left <= 5'd16));         // R5

endmodule

// File: rtl/ep_dma_engine.sv
module ep_dma_engine
    import ep_dma_pkg::*;
#(
    parameter int NCH       = 8,
    parameter int ADDR_W    = 32,
    parameter int CNT_W     = 17,
    parameter int PKT_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [9:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              bm_valid,
    input  logic              bm_ready,
    output logic              bm_wr,
    output logic [ADDR_W-1:0] bm_addr,
    output logic [1:0]        bm_burst,
    output logic [2:0]        bm_nbytes,
    output logic [31:0]       bm_wdata,
    input  logic [31:0]       bm_rdata,
    input  logic              bm_err,
    input  logic [NEP-1:0]    fifo_req,
    output logic [NEP-1:0]    fifo_ack,
    output logic [EP_W-1:0]   fifo_ep,
    output logic [31:0]       fifo_wdata,
    input  logic [31:0]       fifo_rdata
);

    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;
    localparam logic [9:0] INT_ADDR = 10'h200;

    ctrl_t             ctrl_a [NCH];
    logic [ADDR_W-1:0] addr_a [NCH];
    logic [CNT_W-1:0]  cnt_a  [NCH];
    logic [NCH-1:0]    fin, beat_vec, pend;
    logic              beat_err;
    logic [5:0]        row_off;
    logic              in_win, is_int;
    logic [CH_W-1:0]   ch_sel;
    logic [3:0]        reg_off;

    always_comb begin
        row_off = reg_addr[9:4] - 6'h20;
        in_win  = reg_addr[9] && (row_off < 6'(NCH));
        ch_sel  = row_off[CH_W-1:0];
        reg_off = reg_addr[3:0];
        is_int  = (reg_addr == INT_ADDR);
    end

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic hit;
        assign hit = reg_wr && in_win && (ch_sel == CH_W'(g));
        ep_dma_chan #(
            .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PKT_BYTES(PKT_BYTES)
        ) u_chan (
            .clk       (clk),
            .rst       (rst),
            .wr_ctrl   (hit && reg_off == 4'h4),
            .wr_addr   (hit && reg_off == 4'h8),
            .wr_cnt    (hit && reg_off == 4'hC),
            .wdata     (reg_wdata),
            .beat      (beat_vec[g]),
            .beat_err  (beat_err),
            .beat_bytes(bm_nbytes),
            .ctrl      (ctrl_a[g]),
            .addr      (addr_a[g]),
            .cnt       (cnt_a[g]),
            .fin       (fin[g])
        );
    end

    ep_dma_seq #(.NCH(NCH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .ctrl     (ctrl_a),
        .addr     (addr_a),
        .cnt      (cnt_a),
        .fin      (fin),
        .fifo_req (fifo_req),
        .bm_valid (bm_valid),
        .bm_ready (bm_ready),
        .bm_wr    (bm_wr),
        .bm_addr  (bm_addr),
        .bm_burst (bm_burst),
        .bm_nbytes(bm_nbytes),
        .bm_err   (bm_err),
        .beat_vec (beat_vec),
        .beat_err (beat_err),
        .fifo_ack (fifo_ack),
        .fifo_ep  (fifo_ep)
    );

    // Pending byte: read clears, a same-cycle event still lands.
    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
        end else begin
            logic [NCH-1:0] set_v;
            for (int i = 0; i < NCH; i++) set_v[i] = fin[i] && ctrl_a[i].ie;
            pend <= ((reg_rd && is_int) ? '0 : pend) | set_v;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (is_int) begin
            reg_rdata[NCH-1:0] = pend;
        end else if (in_win) begin
            case (reg_off)
                4'h4:    reg_rdata[15:0] = ctrl_a[ch_sel];
                4'h8:    reg_rdata[ADDR_W-1:0] = addr_a[ch_sel];
                4'hC:    reg_rdata[CNT_W-1:0] = cnt_a[ch_sel];
                default: reg_rdata = '0;
            endcase
        end
    end

    assign irq        = |pend;
    assign bm_wdata   = fifo_rdata;
    assign fifo_wdata = bm_rdata;

    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(fifo_ack));                                           // R11
    AST_ACK_WITH_BEAT: assert property (@(posedge clk) disable iff (rst)
        (fifo_ack != '0) |-> (bm_valid && bm_ready && !bm_err));       // R11

endmodule

// File: tb/tb_ep_dma_engine.sv
module tb_ep_dma_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [9:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        irq, bm_valid, bm_wr;
    logic        bm_ready = 1'b1, bm_err = 1'b0;
    logic [31:0] bm_addr, bm_wdata, bm_rdata, fifo_wdata, fifo_rdata;
    logic [1:0]  bm_burst;
    logic [2:0]  bm_nbytes;
    logic [15:0] fifo_req = 16'hFFFF, fifo_ack;
    logic [3:0]  fifo_ep;

    always #5 clk = ~clk;

    assign bm_rdata   = bm_addr ^ 32'h5A5A_0000;
    assign fifo_rdata = {28'hC0DE_000, fifo_ep};

    ep_dma_engine dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .bm_valid(bm_valid), .bm_ready(bm_ready), .bm_wr(bm_wr),
        .bm_addr(bm_addr), .bm_burst(bm_burst), .bm_nbytes(bm_nbytes),
        .bm_wdata(bm_wdata), .bm_rdata(bm_rdata), .bm_err(bm_err),
        .fifo_req(fifo_req), .fifo_ack(fifo_ack), .fifo_ep(fifo_ep),
        .fifo_wdata(fifo_wdata), .fifo_rdata(fifo_rdata)
    );

    int n_chk = 0, n_fail = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Bus responder: random ready, one-shot error injection.
    bit ready_rand = 1'b0, err_arm = 1'b0;
    always @(negedge clk) begin
        if (err_arm && bm_valid) begin
            bm_err = 1'b1; bm_ready = 1'b1; err_arm = 1'b0;
        end else begin
            bm_err   = 1'b0;
            bm_ready = ready_rand ? (($urandom % 3) != 0) : 1'b1;
        end
    end

    // Beat monitor.
    int beats, bytes, run, max_run, seq_n, addr_bad, dir_bad, ack_bad, wdat_bad;
    bit track, exp_wr;
    logic [31:0] exp_a;
    logic [3:0]  seq [64];
    always @(posedge clk) begin
        if (!rst) begin
            if (!bm_valid) run = 0;
            else if (bm_ready && !bm_err) begin
                beats++; bytes += int'(bm_nbytes); run++;
                if (run > max_run) max_run = run;
                if (seq_n < 64) begin seq[seq_n] = fifo_ep; seq_n++; end
                if (track) begin
                    if (bm_addr != exp_a) addr_bad++;
                    exp_a = bm_addr + 32'(bm_nbytes);
                    if (bm_wr != exp_wr) dir_bad++;
                end
                if (fifo_ack != (16'h1 << fifo_ep)) ack_bad++;
                if (!bm_wr && fifo_wdata != (bm_addr ^ 32'h5A5A_0000)) wdat_bad++;
                if (bm_wr && bm_wdata != {28'hC0DE_000, fifo_ep}) wdat_bad++;
            end
        end
    end

    task automatic mon_clear(input logic [31:0] a, input bit wrx, input bit trk);
        @(negedge clk);
        beats = 0; bytes = 0; run = 0; max_run = 0; seq_n = 0;
        addr_bad = 0; dir_bad = 0; ack_bad = 0; wdat_bad = 0;
        exp_a = a; exp_wr = wrx; track = trk;
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    function automatic logic [9:0] cb(input int ch);
        return 10'h200 + 10'(ch * 16);
    endfunction

    function automatic logic [31:0] mk_ctrl(input bit en, input bit tx, input bit m1,
                                            input bit ie, input int ep, input int burst);
        return {21'b0, 2'(burst), 1'b0, 4'(ep), ie, m1, tx, en};
    endfunction

    function automatic int blen(input int b);
        case (b) 1: return 4; 2: return 8; 3: return 16; default: return 1; endcase
    endfunction

    function automatic int rr_next(input int prev);
        case (prev) 1: return 4; 4: return 6; default: return 1; endcase
    endfunction

    task automatic wait_done(input int ch);
        logic [31:0] v;
        for (int i = 0; i < 3000; i++) begin
            rd(cb(ch) + 4, v);
            if (!v[0]) break;
        end
    endtask

    task automatic xfer(input int ch, input int ep, input bit tx, input bit m1,
                        input int burst, input logic [31:0] a, input int c, input bit ie);
        mon_clear(a, !tx, 1'b1);
        wr(cb(ch) + 8, a);
        wr(cb(ch) + 12, 32'(c));
        wr(cb(ch) + 4, mk_ctrl(1, tx, m1, ie, ep, burst));
        wait_done(ch);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        finish_up();
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        rd(cb(3) + 4, v); chk(v == 0, "R1 ctrl", v, 0);
        rd(cb(3) + 8, v); chk(v == 0, "R1 addr", v, 0);
        rd(cb(3) + 12, v); chk(v == 0, "R1 count", v, 0);
        rd(10'h200, v); chk(v == 0, "R1 int byte", v, 0);
        chk(!irq && !bm_valid, "R1 irq/valid", {irq, bm_valid}, 0);

        // R2 register map readback
        for (int i = 0; i < 4; i++) begin
            int ch; logic [31:0] a, c, k;
            ch = int'($urandom % 8); a = $urandom; c = $urandom; k = $urandom & 32'hFFFF_FFFE;
            wr(cb(ch) + 8, a); wr(cb(ch) + 12, c); wr(cb(ch) + 4, k);
            rd(cb(ch) + 8, v); chk(v == a, "R2 addr readback", v, a);
            rd(cb(ch) + 12, v); chk(v == (c & 32'h1FFFF), "R2 count readback", v, c & 32'h1FFFF);
            rd(cb(ch) + 4, v); chk(v == (k & 32'h06FE), "R2 ctrl readback", v, k & 32'h06FE);
            wr(cb(ch) + 4, 0);
        end

        // R3 R4 R5 R6 R7 directed transmit, 4-beat bursts
        xfer(5, 5, 1, 1, 1, 32'h1000, 100, 1);
        rd(cb(5) + 8, v); chk(v == 32'h1064, "R4 end address", v, 32'h1064);
        rd(cb(5) + 12, v); chk(v == 0, "R4 count zero", v, 0);
        chk(beats == 25 && bytes == 100, "R4 beats/bytes", beats, 25);
        chk(max_run == 4, "R5 burst length", max_run, 4);
        chk(addr_bad == 0 && dir_bad == 0, "R3 address/direction", addr_bad + dir_bad, 0);
        chk(wdat_bad == 0, "R3 data path", wdat_bad, 0);
        chk(irq, "R7 irq raised", irq, 1);
        rd(10'h200, v); chk(v == 32'h20, "R7 int byte", v, 32'h20);
        rd(10'h200, v); chk(v == 0 && !irq, "R7 read clears", v, 0);

        // R4 R5 random transfers with random back-pressure
        ready_rand = 1'b1;
        for (int i = 0; i < 8; i++) begin
            int ch, ep, b, c, tb; bit tx; logic [31:0] a;
            ch = int'($urandom % 8); ep = int'($urandom % 16); b = int'($urandom % 4);
            c = 1 + int'($urandom % 400); tx = 1'($urandom); a = $urandom & 32'hFFFF_FFFC;
            xfer(ch, ep, tx, 1, b, a, c, 1);
            tb = (c + 3) / 4;
            rd(cb(ch) + 8, v); chk(v == a + 32'(c), "R4 random end address", v, a + 32'(c));
            chk(beats == tb && addr_bad == 0, "R4 random beat count", beats, tb);
            chk(max_run == ((blen(b) < tb) ? blen(b) : tb), "R5 random burst", max_run, blen(b));
            chk(dir_bad == 0 && wdat_bad == 0, "R3 random direction", dir_bad, 0);
            rd(10'h200, v); chk(v == (32'h1 << ch), "R7 random int", v, 32'h1 << ch);
        end
        ready_rand = 1'b0;

        // R6 mode 0 stops after one 64-byte packet spanning bursts
        xfer(2, 2, 0, 0, 1, 32'h8000, 200, 1);
        rd(cb(2) + 8, v); chk(v == 32'h8040, "R6 mode0 address", v, 32'h8040);
        rd(cb(2) + 12, v); chk(v == 136, "R6 mode0 count left", v, 136);
        chk(beats == 16 && max_run == 4, "R6 mode0 beats", beats, 16);
        rd(10'h200, v); chk(v == 32'h04, "R6 mode0 int", v, 32'h04);

        // R7 interrupt enable clear
        xfer(1, 1, 1, 1, 0, 32'h40, 8, 0);
        rd(cb(1) + 12, v); chk(v == 0, "R7 no-ie transfer done", v, 0);
        chk(!irq, "R7 no-ie irq", irq, 0);
        rd(10'h200, v); chk(v == 0, "R7 no-ie int byte", v, 0);

        // R8 bus error on first beat
        mon_clear(0, 0, 0);
        err_arm = 1'b1;
        wr(cb(7) + 8, 32'h3000); wr(cb(7) + 12, 64);
        wr(cb(7) + 4, mk_ctrl(1, 1, 1, 1, 7, 0));
        wait_done(7);
        rd(cb(7) + 4, v); chk(v[8] == 1'b1 && v[0] == 1'b0, "R8 error flag", v, 32'h100);
        rd(cb(7) + 8, v); chk(v == 32'h3000, "R8 address held", v, 32'h3000);
        rd(cb(7) + 12, v); chk(v == 64, "R8 count held", v, 64);
        chk(beats == 0, "R8 no ack on error", beats, 0);
        rd(10'h200, v); chk(v == 32'h80, "R8 int byte", v, 32'h80);

        // R9 abort before any request
        fifo_req = 16'h0;
        mon_clear(0, 0, 0);
        wr(cb(4) + 8, 32'h500); wr(cb(4) + 12, 40);
        wr(cb(4) + 4, mk_ctrl(1, 0, 1, 1, 4, 2));
        repeat (5) @(negedge clk);
        chk(beats == 0, "R3 no beat without request", beats, 0);
        wr(cb(4) + 4, 0);
        fifo_req = 16'hFFFF;
        repeat (20) @(negedge clk);
        chk(beats == 0, "R9 no beat after abort", beats, 0);
        rd(cb(4) + 8, v); chk(v == 32'h500, "R9 address untouched", v, 32'h500);
        rd(10'h200, v); chk(v == 0, "R9 no interrupt", v, 0);

        // R11 endpoint selection
        fifo_req = 16'h0200;
        mon_clear(0, 0, 0);
        wr(cb(0) + 8, 32'h100); wr(cb(0) + 12, 16);
        wr(cb(0) + 4, mk_ctrl(1, 1, 1, 1, 3, 0));
        wr(cb(2) + 8, 32'h200); wr(cb(2) + 12, 16);
        wr(cb(2) + 4, mk_ctrl(1, 1, 1, 1, 9, 0));
        repeat (60) @(negedge clk);
        rd(cb(0) + 12, v); chk(v == 16, "R11 gated channel idle", v, 16);
        rd(cb(2) + 12, v); chk(v == 0, "R11 selected channel done", v, 0);
        begin
            int bad = 0;
            for (int i = 0; i < seq_n; i++) if (seq[i] != 4'd9) bad++;
            chk(bad == 0 && beats == 4, "R11 fifo_ep value", bad, 0);
        end
        chk(ack_bad == 0, "R11 fifo_ack line", ack_bad, 0);
        fifo_req = 16'hFFFF;
        wait_done(0);
        rd(cb(0) + 12, v); chk(v == 0, "R11 released channel done", v, 0);
        rd(10'h200, v); chk(v == 32'h05, "R11 int byte", v, 32'h05);

        // R10 round-robin among channels 1, 4, 6
        fifo_req = 16'h0;
        mon_clear(0, 0, 0);
        foreach (seq[i]) seq[i] = 4'd0;
        for (int k = 0; k < 3; k++) begin
            int ch;
            ch = (k == 0) ? 1 : (k == 1) ? 4 : 6;
            wr(cb(ch) + 8, 32'(ch * 32'h1000)); wr(cb(ch) + 12, 16);
            wr(cb(ch) + 4, mk_ctrl(1, 1, 1, 1, ch, 0));
        end
        fifo_req = 16'hFFFF;
        wait_done(6); wait_done(1); wait_done(4);
        begin
            int bad = 0;
            for (int i = 1; i < 12; i++) if (int'(seq[i]) != rr_next(int'(seq[i-1]))) bad++;
            chk(bad == 0 && seq_n == 12, "R10 rotation order", bad, 0);
        end
        rd(10'h200, v); chk(v == 32'h52, "R10 int byte", v, 32'h52);

        // R12 zero-length start
        mon_clear(0, 0, 0);
        wr(cb(3) + 8, 32'h900); wr(cb(3) + 12, 0);
        wr(cb(3) + 4, mk_ctrl(1, 1, 1, 1, 3, 3));
        repeat (10) @(negedge clk);
        rd(cb(3) + 4, v); chk(v[0] == 1'b0, "R12 enable cleared", v, 0);
        chk(beats == 0, "R12 no beats", beats, 0);
        rd(10'h200, v); chk(v == 32'h08, "R12 int byte", v, 32'h08);

        finish_up();
    end

endmodule